// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex, single-channel asynchronous serial transmitter and receiver. A character has 5 to 8 data bits. It can carry an optional odd or even parity bit and ends with 1, 1.5 or 2 stop bits. All bit timing comes from an external enable tick that pulses at sixteen times the bit rate. The parallel side has one byte of transmit holding, with an empty flag, and one byte of receive holding, with an available flag and per-character error status.

The host writes a byte while the transmit holding is empty. The transmitter moves it into its shifter at the next tick, provided the line is free. When the previous character's stop time ends with another byte already waiting, frames go out back to back. The receiver hunts for a start bit while it is enabled. It confirms the start bit half a bit later, samples every later bit at its centre, and drops the right-justified result into the receive holding. In auto-enable mode, the clear-to-send input must be active before the transmitter launches a character, and the carrier-detect input must be active before the receiver hunts. With auto-enable off, both inputs only appear on registered status outputs.

Top module: `async_serial_xcvr`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `tx_empty` is 1, `rx_avail` is 0 and all three error flags are 0.
- R2: `len_code` selects the character length for both directions: 2'b00 = 5 bits, 2'b01 = 7 bits, 2'b10 = 6 bits, 2'b11 = 8 bits. The received byte is right-justified with zeros above the top data bit, and transmit bits above the length are not sent.
- R3: With `par_en` = 1, a parity bit follows the data bits. With `par_even` = 1 it makes the count of ones over data and parity even, and with `par_even` = 0 it makes that count odd. With `par_en` = 0 there is no parity bit.
- R4: `stop_code` sets the mark time after the last data or parity bit: 2'b10 = 24 ticks (1.5 bits), 2'b11 = 32 ticks (2 bits), and 2'b00 or 2'b01 = 16 ticks (1 bit). When the next byte is already held, its start bit begins right after that time.
- R5: A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then high stop time. Each start, data and parity bit lasts 16 ticks, and the line is high while the transmitter is idle.
- R6: While `rx_en` is 0 the receiver is held idle and sets no flag and no data.
- R7: With `auto_en` = 1, the transmitter does not launch a character while the registered `cts` is 0. The held byte stays and is sent once `cts` goes to 1.
- R8: With `auto_en` = 1, the receiver ignores the line while the registered `cd` is 0.
- R9: `cts_seen` and `cd_seen` follow `cts` and `cd` one clock later. With `auto_en` = 0, neither input affects transmission or reception.
- R10: A `tx_wr` while `tx_empty` is 0 is ignored, and the held byte is kept. `tx_empty` goes to 0 only on an accepted write and returns to 1 when the byte moves to the shifter.
- R11: A low level on the line is taken as a start bit only if it is still low at the 8th tick after detection. A shorter low pulse produces no character.
- R12: A stop bit sampled low sets `err_framing` for that character.
- R13: A character that completes while `rx_avail` is 1 replaces the held byte and sets `err_overrun`. `rx_rd` clears `rx_avail` and `err_overrun`.
- R14: `err_parity` is 1 for a character whose received parity bit fails the selected parity. The parity and framing flags are updated with every completed character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| len_code | input | 2 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_code | input | 2 | Stop time code |
| auto_en | input | 1 | Let cts/cd gate transmitter/receiver |
| rx_en | input | 1 | Receiver enable |
| cts | input | 1 | Clear-to-send, active high |
| cd | input | 1 | Carrier detect, active high |
| cts_seen | output | 1 | Registered cts status |
| cd_seen | output | 1 | Registered cd status |
| tx_data | input | 8 | Byte to transmit, right-justified |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_empty | output | 1 | Transmit holding is free |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Received byte, right-justified |
| rx_avail | output | 1 | Received byte waiting |
| rx_rd | input | 1 | Read strobe, clears rx_avail and overrun |
| err_parity | output | 1 | Parity error of held character |
| err_framing | output | 1 | Framing error of held character |
| err_overrun | output | 1 | A character was overwritten unread |

## Verification
A transmitter phase or bit counter that is off by one shows up within one character as a txd level that is wrong at a bit centre, or as a start-to-start spacing that is 4 clocks off. Both are measured against arithmetic from the codes. A receiver that samples off centre, shifts in the wrong direction or decodes the length wrongly returns a different masked byte or a spurious error flag at the next rx_avail. The loopback sweep covers every length, parity and stop combination. Errors in gating or overrun state show up as a character that arrives when it must not, or as a flag that stays set after a read, within the following frame.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  // Length code: 00->5, 01->7, 10->6, 11->8 data bits.
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    case (code)
      2'b00:   char_bits = 4'd5;
      2'b01:   char_bits = 4'd7;
      2'b10:   char_bits = 4'd6;
      default: char_bits = 4'd8;
    endcase
  endfunction

  function automatic logic [7:0] char_mask(input logic [1:0] code);
    char_mask = 8'hFF >> (4'd8 - char_bits(code));
  endfunction

endpackage

// File: rtl/sx_tx.sv
module sx_tx
  import sx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_even,
  input  logic [1:0] stop_code,
  input  logic       gate_ok,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       txd,
  output logic       empty,
  output logic       idle
);
  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP15_LAST = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] STOP2_LAST = CW'(2 * OVS - 1);

  phase_t        ph;
  logic [7:0]    hold, sh;
  logic          full, par_bit;
  logic [2:0]    bitn;
  logic [CW-1:0] tcnt, stop_last;
  logic [3:0]    nb;
  logic          do_launch;

  always_comb begin
    case (stop_code)
      2'b10:   stop_last = STOP15_LAST;
      2'b11:   stop_last = STOP2_LAST;
      default: stop_last = BIT_LAST;
    endcase
    nb = char_bits(len_code);
    do_launch = tick && full && gate_ok &&
                (ph == PH_IDLE || (ph == PH_STOP && tcnt == stop_last));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;
      full <= 1'b0;
      hold <= '0;
      sh <= '0;
      bitn <= '0;
      tcnt <= '0;
      par_bit <= 1'b0;
      txd <= 1'b1;
    end else begin
      if (wr && !full) begin
        hold <= wdata;
        full <= 1'b1;
      end
      if (do_launch) begin
        sh <= hold;
        full <= 1'b0;
        par_bit <= par_even ? ^(hold & char_mask(len_code))
                            : ~^(hold & char_mask(len_code));
        txd <= 1'b0;
        tcnt <= '0;
        ph <= PH_START;
      end else if (tick) begin
        case (ph)
          PH_START: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              txd <= sh[0];
              sh <= sh >> 1;
              bitn <= '0;
              ph <= PH_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_DATA: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              if ({1'b0, bitn} == nb - 4'd1) begin
                txd <= par_en ? par_bit : 1'b1;
                ph <= par_en ? PH_PAR : PH_STOP;
              end else begin
                txd <= sh[0];
                sh <= sh >> 1;
                bitn <= bitn + 1'b1;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          PH_PAR: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              txd <= 1'b1;
              ph <= PH_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_STOP: begin
            if (tcnt == stop_last) ph <= PH_IDLE;
            else tcnt <= tcnt + 1'b1;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign empty = !full;
  assign idle  = (ph == PH_IDLE);
endmodule

// File: rtl/sx_rx.sv
module sx_rx
  import sx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic       en,
  input  logic       gate_ok,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rd,
  output logic [7:0] data,
  output logic       avail,
  output logic       perr,
  output logic       ferr,
  output logic       oerr
);
  localparam int RW = $clog2(OVS);
  localparam logic [RW-1:0] HALF_LAST = RW'(OVS / 2 - 1);
  localparam logic [RW-1:0] BIT_LAST  = RW'(OVS - 1);

  phase_t        ph;
  logic [RW-1:0] tcnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          pacc, pbad;
  logic [3:0]    nb;

  assign nb = char_bits(len_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;
      tcnt <= '0;
      sh <= '0;
      bitn <= '0;
      pacc <= 1'b0;
      pbad <= 1'b0;
      data <= '0;
      avail <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      oerr <= 1'b0;
    end else begin
      if (rd) begin
        avail <= 1'b0;
        oerr <= 1'b0;
      end
      if (!en) begin
        ph <= PH_IDLE;
      end else if (tick) begin
        case (ph)
          PH_IDLE: begin
            if (gate_ok && !line) begin
              tcnt <= '0;
              ph <= PH_START;
            end
          end
          PH_START: begin
            if (tcnt == HALF_LAST) begin
              tcnt <= '0;
              bitn <= '0;
              pacc <= 1'b0;
              pbad <= 1'b0;
              ph <= line ? PH_IDLE : PH_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_DATA: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              sh <= {line, sh[7:1]};
              pacc <= pacc ^ line;
              if ({1'b0, bitn} == nb - 4'd1) ph <= par_en ? PH_PAR : PH_STOP;
              else bitn <= bitn + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_PAR: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              pbad <= par_even ? (pacc ^ line) : ~(pacc ^ line);
              ph <= PH_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_STOP: begin
            if (tcnt == BIT_LAST) begin
              tcnt <= '0;
              data <= sh >> (4'd8 - nb);
              avail <= 1'b1;
              oerr <= avail && !rd;
              perr <= par_en && pbad;
              ferr <= !line;
              ph <= PH_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr #(
  parameter int OVS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_even,
  input  logic [1:0] stop_code,
  input  logic       auto_en,
  input  logic       rx_en,
  input  logic       cts,
  input  logic       cd,
  output logic       cts_seen,
  output logic       cd_seen,
  input  logic [7:0] tx_data,
  input  logic       tx_wr,
  output logic       tx_empty,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_avail,
  input  logic       rx_rd,
  output logic       err_parity,
  output logic       err_framing,
  output logic       err_overrun
);
  logic [SYNC_STAGES-1:0] rx_sync;
  logic tx_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sync  <= '1;
      cts_seen <= 1'b0;
      cd_seen  <= 1'b0;
    end else begin
      rx_sync  <= {rx_sync[SYNC_STAGES-2:0], rxd};
      cts_seen <= cts;
      cd_seen  <= cd;
    end
  end

  sx_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .len_code(len_code),
    .par_en(par_en), .par_even(par_even), .stop_code(stop_code),
    .gate_ok(!auto_en || cts_seen), .wr(tx_wr), .wdata(tx_data),
    .txd(txd), .empty(tx_empty), .idle(tx_idle)
  );

  sx_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .line(rx_sync[SYNC_STAGES-1]),
    .en(rx_en), .gate_ok(!auto_en || cd_seen), .len_code(len_code),
    .par_en(par_en), .par_even(par_even), .rd(rx_rd),
    .data(rx_data), .avail(rx_avail), .perr(err_parity),
    .ferr(err_framing), .oerr(err_overrun)
  );
endmodule

// File: rtl/sx_checker.sv
module sx_checker (
  input logic clk,
  input logic rst,
  input logic auto_en,
  input logic cts_seen,
  input logic rx_en,
  input logic tx_wr,
  input logic tx_empty,
  input logic txd,
  input logic rx_avail,
  input logic err_overrun,
  input logic tx_idle
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (txd && tx_empty && !rx_avail && !err_overrun));

  assert_idle_marks_R5: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> txd);

  assert_rx_held_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rx_avail) |=> !rx_avail);

  assert_cts_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_idle && auto_en && !cts_seen) |=> tx_idle);

  assert_hold_by_write_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_empty) |-> $past(tx_wr));

  assert_overrun_needs_avail_R13: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $past(rx_avail));
endmodule

bind async_serial_xcvr sx_checker u_chk (
  .clk(clk), .rst(rst), .auto_en(auto_en), .cts_seen(cts_seen),
  .rx_en(rx_en), .tx_wr(tx_wr), .tx_empty(tx_empty), .txd(txd),
  .rx_avail(rx_avail), .err_overrun(err_overrun), .tx_idle(tx_idle)
);

// File: tb/test_async_serial_xcvr.sv
`timescale 1ns/1ps
module test_async_serial_xcvr;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] tdiv = 2'd0;
  logic tick;
  logic [1:0] len_code = 2'b11, stop_code = 2'b01;
  logic par_en = 1'b0, par_even = 1'b0, auto_en = 1'b0, rx_en = 1'b1;
  logic cts = 1'b0, cd = 1'b0, cts_seen, cd_seen;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic tx_wr = 1'b0, tx_empty, txd, rx_rd = 1'b0, rx_avail;
  logic err_parity, err_framing, err_overrun;
  logic loop = 1'b1, rxd_b = 1'b1, rxd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);
  assign rxd = loop ? txd : rxd_b;

  async_serial_xcvr i_async_serial_xcvr (
    .clk(clk), .rst(rst), .tick(tick), .len_code(len_code), .par_en(par_en),
    .par_even(par_even), .stop_code(stop_code), .auto_en(auto_en), .rx_en(rx_en),
    .cts(cts), .cd(cd), .cts_seen(cts_seen), .cd_seen(cd_seen),
    .tx_data(tx_data), .tx_wr(tx_wr), .tx_empty(tx_empty), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_avail(rx_avail), .rx_rd(rx_rd),
    .err_parity(err_parity), .err_framing(err_framing), .err_overrun(err_overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic int nbits(input logic [1:0] c);
    return (c == 2'b00) ? 5 : (c == 2'b01) ? 7 : (c == 2'b10) ? 6 : 8;
  endfunction

  function automatic int stop_ticks(input logic [1:0] c);
    return (c == 2'b10) ? 24 : (c == 2'b11) ? 32 : 16;
  endfunction

  function automatic logic par_of(input logic [7:0] d, input int n, input bit even);
    logic x = 1'b0;
    for (int i = 0; i < n; i++) x = x ^ d[i];
    return even ? x : ~x;
  endfunction

  task automatic write_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1;
    wclk(1);
    tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    wclk(1);
    rx_rd = 1'b0;
  endtask

  task automatic expect_rx(input logic [7:0] d, input bit pe, input bit fe,
                           input bit oe, input string req);
    int t = 0;
    while (!rx_avail && t < 4000) begin wclk(1); t++; end
    chk(rx_avail == 1'b1, {req, " avail"}, int'(rx_avail), 1);
    chk(rx_data == d, {req, " data"}, int'(rx_data), int'(d));
    chk(err_parity == pe, "R14 parity flag", int'(err_parity), int'(pe));
    chk(err_framing == fe, "R12 framing flag", int'(err_framing), int'(fe));
    chk(err_overrun == oe, "R13 overrun flag", int'(err_overrun), int'(oe));
    read_rx();
    chk(rx_avail == 1'b0 && err_overrun == 1'b0, "R13 read clears",
        int'({rx_avail, err_overrun}), 0);
  endtask

  // Drive one frame on the line from the bench; 64 clocks per bit.
  task automatic drive_frame(input logic [7:0] d, input int n, input int pm,
                             input bit flip_par, input bit bad_stop);
    rxd_b = 1'b0; wclk(64);
    for (int i = 0; i < n; i++) begin rxd_b = d[i]; wclk(64); end
    if (pm != 0) begin rxd_b = par_of(d, n, pm == 2) ^ flip_par; wclk(64); end
    rxd_b = !bad_stop; wclk(64);
    rxd_b = 1'b1; wclk(64);
  endtask

  // Loopback: two back-to-back characters, bit-centre and spacing checks.
  task automatic sweep_one(input logic [1:0] lc, input int pm, input logic [1:0] sc,
                           input logic [7:0] a, input logic [7:0] b);
    int n, p, s;
    logic [7:0] m;
    len_code = lc; par_en = (pm != 0); par_even = (pm == 2); stop_code = sc;
    n = nbits(lc); p = (pm != 0) ? 1 : 0; s = stop_ticks(sc);
    m = 8'hFF >> (8 - n);
    wclk(8);
    write_tx(a);
    while (!tx_empty) wclk(1);   // same edge as the start bit falling
    write_tx(b);
    wclk(31);
    chk(txd == 1'b0, "R5 start bit", int'(txd), 0);
    for (int i = 0; i < n; i++) begin
      wclk(64);
      chk(txd == a[i], "R2 R5 data bit lsb first", int'(txd), int'(a[i]));
    end
    if (p == 1) begin
      wclk(64);
      chk(txd == par_of(a, n, pm == 2), "R3 parity bit", int'(txd),
          int'(par_of(a, n, pm == 2)));
    end
    wclk(64);
    chk(txd == 1'b1, "R5 stop mark", int'(txd), 1);
    wclk(s * 4 - 32 - 2);
    chk(txd == 1'b1, "R4 stop still marking", int'(txd), 1);
    wclk(4);
    chk(txd == 1'b0, "R4 next start after stop time", int'(txd), 0);
    expect_rx(a & m, 1'b0, 1'b0, 1'b0, "R2 loopback first");
    expect_rx(b & m, 1'b0, 1'b0, 1'b0, "R3 loopback second");
    wclk(200);
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(1);
    chk(txd == 1'b1 && tx_empty == 1'b1, "R1 reset tx", int'({txd, tx_empty}), 3);
    chk(rx_avail == 1'b0 && {err_parity, err_framing, err_overrun} == 3'b000,
        "R1 reset rx", int'({rx_avail, err_parity, err_framing, err_overrun}), 0);

    // Full configuration sweep in loopback.
    for (int li = 0; li < 4; li++)
      for (int pm = 0; pm < 3; pm++)
        for (int si = 1; si < 4; si++) begin
          logic [7:0] a = 8'(li * 71 + pm * 29 + si * 13 + 5);
          sweep_one(2'(li), pm, 2'(si), a, ~a ^ 8'h24);
        end

    // Bench-driven frames, 7 data bits, even parity, 1 stop.
    loop = 1'b0; len_code = 2'b01; par_en = 1'b1; par_even = 1'b1; stop_code = 2'b01;
    wclk(10);
    drive_frame(8'h5B, 7, 2, 1'b1, 1'b0);
    expect_rx(8'h5B, 1'b1, 1'b0, 1'b0, "R14 bad parity");
    drive_frame(8'h33, 7, 1, 1'b0, 1'b0);
    expect_rx(8'h33, 1'b1, 1'b0, 1'b0, "R14 odd frame vs even check");
    drive_frame(8'h4C, 7, 2, 1'b0, 1'b1);
    expect_rx(8'h4C, 1'b0, 1'b1, 1'b0, "R12 missing stop");
    drive_frame(8'h2A, 7, 2, 1'b0, 1'b0);
    expect_rx(8'h2A, 1'b0, 1'b0, 1'b0, "R12 flags refresh");

    // Overrun, 8 bits no parity.
    len_code = 2'b11; par_en = 1'b0;
    drive_frame(8'hA1, 8, 0, 1'b0, 1'b0);
    drive_frame(8'h7E, 8, 0, 1'b0, 1'b0);
    expect_rx(8'h7E, 1'b0, 1'b0, 1'b1, "R13 overrun");

    // Short low pulse is not a start bit.
    rxd_b = 1'b0; wclk(12); rxd_b = 1'b1; wclk(1200);
    chk(rx_avail == 1'b0, "R11 glitch rejected", int'(rx_avail), 0);
    drive_frame(8'hC3, 8, 0, 1'b0, 1'b0);
    expect_rx(8'hC3, 1'b0, 1'b0, 1'b0, "R11 valid after glitch");

    // Receiver disabled.
    rx_en = 1'b0;
    drive_frame(8'h99, 8, 0, 1'b0, 1'b0);
    chk(rx_avail == 1'b0, "R6 receiver disabled", int'(rx_avail), 0);
    rx_en = 1'b1; wclk(10);

    // Carrier gating.
    auto_en = 1'b1; cd = 1'b0; wclk(4);
    drive_frame(8'h66, 8, 0, 1'b0, 1'b0);
    chk(rx_avail == 1'b0, "R8 cd low blocks receiver", int'(rx_avail), 0);
    cd = 1'b1; wclk(4);
    drive_frame(8'h67, 8, 0, 1'b0, 1'b0);
    expect_rx(8'h67, 1'b0, 1'b0, 1'b0, "R8 cd high receives");

    // CTS gating and write-while-full.
    loop = 1'b1; cts = 1'b0; wclk(4);
    write_tx(8'h3C);
    write_tx(8'hE1);
    wclk(2000);
    chk(txd == 1'b1 && tx_empty == 1'b0, "R7 cts low holds byte",
        int'({txd, tx_empty}), 2);
    chk(rx_avail == 1'b0, "R7 nothing sent", int'(rx_avail), 0);
    cts = 1'b1;
    expect_rx(8'h3C, 1'b0, 1'b0, 1'b0, "R10 second write ignored");
    chk(tx_empty == 1'b1, "R10 holding freed", int'(tx_empty), 1);
    wclk(300);
    chk(rx_avail == 1'b0, "R10 no extra char", int'(rx_avail), 0);

    // Status mirrors and no gating with auto-enable clear.
    auto_en = 1'b0; cts = 1'b1; cd = 1'b0; wclk(2);
    chk(cts_seen == 1'b1 && cd_seen == 1'b0, "R9 status mirrors",
        int'({cts_seen, cd_seen}), 2);
    cts = 1'b0; cd = 1'b1; wclk(2);
    chk(cts_seen == 1'b0 && cd_seen == 1'b1, "R9 status follows",
        int'({cts_seen, cd_seen}), 1);
    cd = 1'b0;
    write_tx(8'h81);
    expect_rx(8'h81, 1'b0, 1'b0, 1'b0, "R9 no gating when auto clear");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule